// File: doc/BRIEF.md
# Transition-Signalling Join Monitor

This block is a clocked model of a two-input join (C-element style) that communicates by transition signalling. An event on an input is a change of its level, not the level itself. The block registers each input level and recognises a toggle by comparing the current level with the level from the previous clock. It remembers which inputs have toggled since the last output event. Once both inputs have an outstanding event, the output toggles one clock later and the outstanding set is emptied.

The environment must not toggle an input while the block holds an event on both inputs and owes its output. If it does, the block enters a sticky chaos state and raises a fault flag. In that state every input pattern is accepted, the output is frozen, and only a synchronous reset brings the block back. The block is meant for checking handshakes in clocked models of self-timed logic. It can sit beside a producer and consumer pair and flag any protocol breach.

Top module: `tsig_join_monitor`

## Requirements
- R1: After synchronous reset (rst high at a rising edge) out_c and fault are 0, the outstanding set is empty and both stored input levels are low.
- R2: A toggle on only one input, with no toggle on the other, never changes out_c.
- R3: When the second of the two input events is registered at an edge, out_c keeps its value at that edge and toggles at the next edge. The outstanding set is then empty.
- R4: A second toggle of the same input, before out_c has fired, withdraws that input's event. The other input alone then cannot make out_c fire.
- R5: If in_a and in_b toggle in the same cycle from the empty set, both events count, and out_c toggles at the following edge.
- R6: Any input toggle in a cycle where both events are outstanding sets fault to 1 at that edge, and out_c does not toggle.
- R7: Once fault is 1 it stays 1 and out_c holds its value, whatever the inputs do, until reset.
- R8: Reset clears fault and returns the block to normal operation.
- R9: out_c never toggles on two consecutive clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | First transition-signalled input level |
| in_b | input | 1 | Second transition-signalled input level |
| out_c | output | 1 | Output level; each toggle is one output event |
| fault | output | 1 | Sticky protocol violation flag |

## Verification
On every cycle the assertions check four things: the fault flag is sticky, out_c is frozen while the flag is set and on the edge where the flag rises, out_c never toggles twice in a row, and every output toggle leaves the outstanding set empty. Only the bench scenarios can show the event bookkeeping itself. That covers when an output event is owed, withdrawal by a repeated toggle, simultaneous toggles, and the exact edge at which a violation is caught. The bench checks these against its own event model, under directed sequences and seeded random traffic.

// File: rtl/tsig_join_monitor.sv
module tsig_join_monitor (
  input  logic clk,
  input  logic rst,
  input  logic in_a,
  input  logic in_b,
  output logic out_c,
  output logic fault
);

  logic a_q, b_q;
  logic pend_a, pend_b;
  logic ev_a, ev_b;
  logic owed;

  assign ev_a = in_a ^ a_q;
  assign ev_b = in_b ^ b_q;
  assign owed = pend_a & pend_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      pend_a <= 1'b0;
      pend_b <= 1'b0;
      out_c  <= 1'b0;
      fault  <= 1'b0;
    end else begin
      a_q <= in_a;
      b_q <= in_b;
      if (!fault) begin
        if (owed) begin
          if (ev_a || ev_b) begin
            fault <= 1'b1;
          end else begin
            out_c  <= ~out_c;
            pend_a <= 1'b0;
            pend_b <= 1'b0;
          end
        end else begin
          pend_a <= pend_a ^ ev_a;
          pend_b <= pend_b ^ ev_b;
        end
      end
    end
  end

endmodule

module tsig_join_checker (
  input logic clk,
  input logic rst,
  input logic out_c,
  input logic fault,
  input logic pend_a,
  input logic pend_b
);

  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  p_hold_c_r7: assert property (@(posedge clk) disable iff (rst)
    fault |=> $stable(out_c));

  p_no_fire_on_fault_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> $stable(out_c));

  p_no_double_r9: assert property (@(posedge clk) disable iff (rst)
    (out_c != $past(out_c)) |=> (out_c == $past(out_c)));

  p_fire_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (out_c != $past(out_c)) |-> (!pend_a && !pend_b));

endmodule

bind tsig_join_monitor tsig_join_checker u_chk (
  .clk(clk), .rst(rst), .out_c(out_c), .fault(fault),
  .pend_a(pend_a), .pend_b(pend_b)
);

// File: tb/test_tsig_join_monitor.sv
module test_tsig_join_monitor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_a = 1'b0;
  logic in_b = 1'b0;
  logic out_c, fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic ma, mb, mpa, mpb, mc, mf;

  tsig_join_monitor i_tsig_join_monitor (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b),
    .out_c(out_c), .fault(fault)
  );

  always #4 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] model_next(input logic na, input logic nb);
    logic ea, eb, pa, pb, c, f;
    ea = na ^ ma; eb = nb ^ mb;
    pa = mpa; pb = mpb; c = mc; f = mf;
    if (!f) begin
      if (pa && pb) begin
        if (ea || eb) f = 1'b1;
        else begin c = ~c; pa = 1'b0; pb = 1'b0; end
      end else begin
        pa = pa ^ ea; pb = pb ^ eb;
      end
    end
    return {pa, pb, c, f};
  endfunction

  task automatic step(input logic na, input logic nb, input string tag);
    logic [3:0] nx;
    nx = model_next(na, nb);
    in_a = na; in_b = nb;
    @(posedge clk);
    {mpa, mpb, mc, mf} = nx;
    ma = na; mb = nb;
    @(negedge clk);
    check(out_c, mc, tag, "out_c");
    check(fault, mf, tag, "fault");
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1; in_a = 1'b0; in_b = 1'b0;
    @(posedge clk);
    @(negedge clk);
    ma = 0; mb = 0; mpa = 0; mpb = 0; mc = 0; mf = 0;
    check(out_c, 1'b0, tag, "out_c after reset");
    check(fault, 1'b0, tag, "fault after reset");
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset("R1");

    // R2: single input only
    step(1, 0, "R2"); step(1, 0, "R2"); step(1, 0, "R2");
    check(out_c, 1'b0, "R2", "no output from one input");
    // R3: second event, fire one edge later
    step(1, 1, "R3");
    check(out_c, 1'b0, "R3", "not yet fired");
    step(1, 1, "R3");
    check(out_c, 1'b1, "R3", "fired");
    step(1, 1, "R3");
    // R4: withdraw a, then b alone must not fire
    step(0, 1, "R4"); step(1, 1, "R4"); step(1, 0, "R4");
    step(1, 0, "R4"); step(1, 0, "R4");
    check(out_c, 1'b1, "R4", "withdrawn event holds output");
    step(0, 0, "R4"); step(0, 0, "R4");
    check(out_c, 1'b0, "R4", "fires after a re-toggled");
    // R5: simultaneous toggles
    step(1, 1, "R5"); step(1, 1, "R5");
    check(out_c, 1'b1, "R5", "fires after joint toggle");
    // R6: violation while output owed
    step(0, 1, "R6"); step(0, 0, "R6");
    step(1, 0, "R6");
    check(fault, 1'b1, "R6", "fault raised");
    check(out_c, 1'b1, "R6", "output not fired");
    // R7: sticky, output frozen
    for (int i = 0; i < 20; i++) step(1'($urandom), 1'($urandom), "R7");
    check(fault, 1'b1, "R7", "fault sticky");
    check(out_c, 1'b1, "R7", "output frozen");
    // R8: reset recovers
    do_reset("R8");
    step(1, 1, "R8"); step(1, 1, "R8");
    check(out_c, 1'b1, "R8", "normal after reset");

    // random traffic, R3 and R9 by model comparison
    for (int i = 0; i < 4000; i++) begin
      logic na, nb;
      na = ma; nb = mb;
      if (mf) begin
        if ($urandom % 8 == 0) begin do_reset("R8"); continue; end
        na = 1'($urandom); nb = 1'($urandom);
      end else if (mpa && mpb) begin
        if ($urandom % 40 == 0) begin
          if ($urandom % 2 == 0) na = ~na; else nb = ~nb;
        end
      end else begin
        if ($urandom % 3 == 0) na = ~na;
        if ($urandom % 3 == 0) nb = ~nb;
      end
      step(na, nb, "R3");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule